// File: doc/BRIEF.md
# Multi-Channel Timer Unit Frontend

This block is the shared front end of a general-purpose timer peripheral. It holds a 16-bit reloading prescaler. The prescaler produces one common tick enable, and up to eight timer channels count on that tick. The block also synthesises a read-only capability word. It decodes every 32-bit register access, sending the access either to its own unit registers or to the register window of one channel.

A bus master drives a simple access port made of a valid, a write flag, an 8-bit byte address and 32-bit write data. Reads complete combinationally in the same cycle. Each channel submodule receives a one-hot select, a shared write flag, a word offset inside its window and the write data. It returns a 32-bit read word. The frontend returns that word to the master when the access targets that channel.

Top module: `tmr_unit_front`

## Requirements
- R1: Unit registers: byte offset 0x00 reads the running prescaler count, 0x04 reads the prescaler reload value and 0x08 reads the capability word. A write to 0x00 or 0x04 updates the matching register.
- R2: The prescaler count and reload are 16 bits wide. Bits 31:16 of a write are discarded, and bits 31:16 read as zero.
- R3: After reset the prescaler count and reload are both 0, so the tick enable is high on every clock.
- R4: The prescaler counts down by one per clock. While the count is zero, the tick enable is high for that single clock and the count reloads from the reload register. The tick period is therefore reload+1 clocks.
- R5: A write to offset 0x00 loads the running count directly. After that write edge, the first tick comes after exactly that many clocks.
- R6: A write to the reload register does not disturb the running count. It is used first at the next reload.
- R7: The capability word has bits 2:0 equal to the channel count modulo 8 and bits 7:3 equal to the base interrupt line. Bit 8 is 1 (one interrupt per channel) and bit 9 is 1 (freeze not available). All other bits are 0.
- R8: The capability word is read-only, and a write to 0x08 leaves it unchanged.
- R9: Channel n (0 to NUM_CH-1) owns the 16-byte window at 0x10+0x10*n. Window offsets 0x0, 0x4 and 0x8 are presented as word offset 0, 1 and 2 with only that channel's select high. A read returns that channel's read word.
- R10: An access is unmapped when its address has bits 1:0 not zero, when its window offset is 0xC, or when its window is beyond the last channel. An unmapped read returns 0, and an unmapped write changes no register and raises no channel select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 for write, 0 for read |
| accAddr | input | 8 | Byte address of the access |
| accWdata | input | 32 | Write data |
| accRdata | output | 32 | Read data, valid in the cycle of a read |
| tickEn | output | 1 | Common prescaler tick enable |
| chanValid | output | NUM_CH | One-hot channel select |
| chanWrite | output | 1 | Write flag forwarded to channels |
| chanOff | output | 2 | Word offset inside the channel window |
| chanWdata | output | 32 | Write data forwarded to channels |
| chanRdata | input | 32*NUM_CH | Read words from the channels, channel n in bits 32n+31:32n |

## Verification
The bench builds the block with three channels and base interrupt line 5. With three channels, both valid channel windows and an out-of-range window exist inside the 8-bit address space. A read sweep over every byte address from 0x01 to 0xFF reaches every mapped, misaligned, offset-0xC and out-of-range case. Every pair of reload 0 to 4 and loaded count 0 to 4 is swept, and tick positions are predicted arithmetically. A reload written while a count is running shows that the new reload takes effect only at the next reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // strobes the decoder hands to the datapath
  typedef struct packed {
    logic valueWr;
    logic reloadWr;
    logic rdValue;
    logic rdReload;
    logic rdCap;
    logic rdChan;
  } unitStrobeT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [7:0]        accAddr,
  output unitStrobeT        strobe,
  output logic [NUM_CH-1:0] chanValid,
  output logic [1:0]        chanOff,
  output logic [2:0]        chanIdx
);
  localparam logic [4:0] LAST_WIN = 5'(NUM_CH);

  logic [3:0] win;
  logic [1:0] word;
  logic       aligned;
  logic       unitHit;
  logic       chanHit;

  assign win     = accAddr[7:4];
  assign word    = accAddr[3:2];
  assign aligned = (accAddr[1:0] == 2'b00);
  assign unitHit = accValid && aligned && (win == 4'd0) && (word != 2'd3);
  assign chanHit = accValid && aligned && (win != 4'd0) &&
                   ({1'b0, win} <= LAST_WIN) && (word != 2'd3);

  always_comb begin
    strobe          = '0;
    strobe.valueWr  = unitHit && accWrite && (word == 2'd0);
    strobe.reloadWr = unitHit && accWrite && (word == 2'd1);
    strobe.rdValue  = unitHit && !accWrite && (word == 2'd0);
    strobe.rdReload = unitHit && !accWrite && (word == 2'd1);
    strobe.rdCap    = unitHit && !accWrite && (word == 2'd2);
    strobe.rdChan   = chanHit && !accWrite;
  end

  assign chanOff = word;
  assign chanIdx = 3'(win - 4'd1);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
    assign chanValid[n] = chanHit && (win == 4'(n + 1));
  end

  // R9: at most one channel selected
  p_chan_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanValid));
  // R10: misaligned access reaches nothing
  p_misaligned_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr[1:0] != 2'b00) |-> (chanValid == '0 && strobe == '0));
  // R10: offset 0xC of any window reaches nothing
  p_offc_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr[3:2] == 2'd3) |-> (chanValid == '0 && strobe == '0));
endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8,
  parameter int PRESC_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  unitStrobeT           strobe,
  input  logic [2:0]           chanIdx,
  input  logic [31:0]          accWdata,
  input  logic [32*NUM_CH-1:0] chanRdata,
  output logic [31:0]          accRdata,
  output logic                 tickEn
);
  localparam logic [31:0] CAP_WORD = 32'(NUM_CH % 8) | (32'(IRQ_BASE % 32) << 3) | 32'h300;

  logic [PRESC_W-1:0] cnt;
  logic [PRESC_W-1:0] reloadReg;
  logic [31:0]        chanWord [NUM_CH];

  assign tickEn = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      reloadReg <= '0;
    end else begin
      if (strobe.reloadWr) reloadReg <= accWdata[PRESC_W-1:0];
      if (strobe.valueWr)  cnt <= accWdata[PRESC_W-1:0];
      else if (tickEn)     cnt <= reloadReg;
      else                 cnt <= cnt - 1'b1;
    end
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_word
    assign chanWord[n] = chanRdata[32*n +: 32];
  end

  always_comb begin
    accRdata = '0;
    if (strobe.rdValue)  accRdata = 32'(cnt);
    if (strobe.rdReload) accRdata = 32'(reloadReg);
    if (strobe.rdCap)    accRdata = CAP_WORD;
    for (int n = 0; n < NUM_CH; n++) begin
      if (strobe.rdChan && chanIdx == 3'(n)) accRdata = chanWord[n];
    end
  end

  // R4: a non-zero count steps down by one
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.valueWr) |=> (cnt == $past(cnt) - 1'b1));
  // R4: with non-zero reload a tick lasts a single clock
  p_tick_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && reloadReg != '0 && !strobe.valueWr && !strobe.reloadWr) |=> !tickEn);
  // R5: a value write lands in the counter
  p_value_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.valueWr |=> (cnt == $past(accWdata[PRESC_W-1:0])));
  // R6: reload only moves on its own write
  p_reload_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.reloadWr |=> $stable(reloadReg));
endmodule

// File: rtl/tmr_unit_front.sv
module tmr_unit_front
  import tmr_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int IRQ_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [7:0]           accAddr,
  input  logic [31:0]          accWdata,
  output logic [31:0]          accRdata,
  output logic                 tickEn,
  output logic [NUM_CH-1:0]    chanValid,
  output logic                 chanWrite,
  output logic [1:0]           chanOff,
  output logic [31:0]          chanWdata,
  input  logic [32*NUM_CH-1:0] chanRdata
);
  unitStrobeT strobe;
  logic [2:0] chanIdx;

  tmr_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .strobe(strobe), .chanValid(chanValid),
    .chanOff(chanOff), .chanIdx(chanIdx)
  );

  tmr_dpath #(.NUM_CH(NUM_CH), .IRQ_BASE(IRQ_BASE), .PRESC_W(16)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanIdx(chanIdx),
    .accWdata(accWdata), .chanRdata(chanRdata), .accRdata(accRdata),
    .tickEn(tickEn)
  );

  assign chanWrite = accWrite;
  assign chanWdata = accWdata;
endmodule

// File: tb/tmr_unit_front_tb.sv
module tmr_unit_front_tb_top;
  localparam int NCH = 3;
  localparam int IRQB = 5;
  localparam logic [31:0] CAPX = 32'd811;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [7:0] accAddr = '0;
  logic [31:0] accWdata = '0;
  logic [31:0] accRdata, chanWdata;
  logic tickEn, chanWrite;
  logic [NCH-1:0] chanValid;
  logic [1:0] chanOff;
  logic [32*NCH-1:0] chanRdata;
  int total = 0, bad = 0;
  logic [NCH-1:0] seenValid;
  logic [1:0] seenOff;

  always #2 clk = ~clk;

  for (genvar n = 0; n < NCH; n++) begin : g_stub
    assign chanRdata[32*n +: 32] = {16'hC0DE, 8'(n), 6'd0, chanOff};
  end

  tmr_unit_front #(.NUM_CH(NCH), .IRQ_BASE(IRQB)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accWdata(accWdata), .accRdata(accRdata), .tickEn(tickEn),
    .chanValid(chanValid), .chanWrite(chanWrite), .chanOff(chanOff),
    .chanWdata(chanWdata), .chanRdata(chanRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b1; accAddr = a; accWdata = d;
    #1 seenValid = chanValid; seenOff = chanOff;
    @(posedge clk);
    #1 accValid = 1'b0; accWrite = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    accValid = 1'b1; accWrite = 1'b0; accAddr = a;
    #1 d = accRdata;
    @(posedge clk);
    #1 accValid = 1'b0;
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a, input logic [31:0] rel);
    int win = int'(a[7:4]);
    int wrd = int'(a[3:2]);
    if (a[1:0] != 2'b00 || wrd == 3) return 32'd0;
    if (win == 0) return (wrd == 1) ? rel : (wrd == 2) ? CAPX : 32'd0;
    if (win <= NCH) return {16'hC0DE, 8'(win - 1), 6'd0, 2'(wrd)};
    return 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R3: reset state ticks every clock, registers zero
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); check("R3 tick after reset", 32'(tickEn), 32'd1);
    end
    doRead(8'h00, rd); check("R3 count reset", rd, 32'd0);
    doRead(8'h04, rd); check("R3 reload reset", rd, 32'd0);
    // R7 capability word
    doRead(8'h08, rd); check("R7 capability", rd, CAPX);
    // R8 read-only
    doWrite(8'h08, 32'hFFFF_FFFF);
    doRead(8'h08, rd); check("R8 capability unchanged", rd, CAPX);
    // R2 upper bits discarded
    doWrite(8'h04, 32'hABCD_1234);
    doRead(8'h04, rd); check("R2 reload width", rd, 32'h0000_1234);
    doWrite(8'h00, 32'h5555_0009);
    doRead(8'h00, rd); check("R1 R5 count load read", rd, 32'd9);
    // R10 misaligned write ignored
    doWrite(8'h05, 32'h0000_7777);
    check("R10 misaligned no select", 32'(seenValid), 32'd0);
    doRead(8'h04, rd); check("R10 misaligned write ignored", rd, 32'h0000_1234);
    // R10 out-of-range and offset C writes not forwarded
    doWrite(8'h40, 32'h1);
    check("R10 out-of-range no select", 32'(seenValid), 32'd0);
    doWrite(8'h1C, 32'h1);
    check("R10 offset C no select", 32'(seenValid), 32'd0);
    // R9 channel write routing
    for (int n = 0; n < NCH; n++) begin
      for (int w = 0; w < 3; w++) begin
        doWrite(8'(16 + 16 * n + 4 * w), 32'h0);
        check("R9 channel select", 32'(seenValid), 32'(1 << n));
        check("R9 channel offset", 32'(seenOff), 32'(w));
      end
    end
    // R1 R9 R10 read sweep
    for (int a = 1; a < 256; a++) begin
      doRead(8'(a), rd);
      check("R1 R9 R10 read sweep", rd, expRead(8'(a), 32'h0000_1234));
    end
    // R4 R5 tick sweep
    for (int r = 0; r < 5; r++) begin
      for (int v = 0; v < 5; v++) begin
        doWrite(8'h04, 32'(r));
        doWrite(8'h00, 32'(v));
        for (int i = 0; i < 24; i++) begin
          @(negedge clk);
          check("R4 R5 tick position", 32'(tickEn),
                32'((i >= v) && ((i - v) % (r + 1) == 0)));
        end
      end
    end
    // R6 reload change while counting
    doWrite(8'h04, 32'd2);
    doWrite(8'h00, 32'd6);
    doWrite(8'h04, 32'd4);
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      check("R6 late reload", 32'(tickEn), 32'(i == 6 || i == 11 || i == 16));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule